// File: doc/BRIEF.md
# Armed Single-Pulse Clock Gate

This block sits between a free-running source clock and a set of differential clock output pairs. It oversamples the source clock level in the system clock domain and normally passes it through to every enabled pair. A one-byte control register, written through a simple byte-write strobe, can switch the block into a single-pulse mode. In that mode the outputs rest at clock-low, and each requested shot releases exactly one high phase of the source clock.

A shot is requested by a low-to-high change of the shoot bit. The change is judged only when a write completes, and only when the written byte also keeps the arm bit set. The pulse starts at the next rising edge of the synchronized source. It lasts as long as that source high phase, so it is never a truncated phase. Each pair has its own enable input. A disabled pair rests at clock-low and shows no pulse, while the other pairs keep working.

Top module: `oneshot_clk_gate`

## Requirements
- R1: After reset the control byte reads 0x00, every true output is 0 and every complementary output is 1.
- R2: With the arm bit (bit 6) low, each enabled true output follows `src_clk_i`, delayed by SYNC_STAGES+1 system clock cycles.
- R3: A write with `wr_i` high stores all eight bits of `wr_data_i`, and `rd_data_o` returns that byte from the next cycle on.
- R4: While the arm bit is high and no pulse is being released, every true output is 0 and every complementary output is 1.
- R5: A shot request is a completed write (`wr_i` high) whose bit 7 (shoot) is 1 while the stored bit 7 is 0, and whose bit 6 is 1. A value on `wr_data_i` while `wr_i` is low has no effect.
- R6: A request produces exactly one pulse. It starts at the next rising edge of the synchronized source, and its width in cycles equals the source high phase.
- R7: Writing 1 to the shoot bit while it already holds 1 produces no pulse. A write of 0 to the bit first makes it fire again.
- R8: A request that arrives while an earlier pulse is waiting or being released is dropped.
- R9: A request written with the arm bit 0 is discarded and produces no pulse when the arm bit is set later.
- R10: A write that clears the arm bit aborts any waiting or running pulse, and the outputs return to free-running as in R2.
- R11: A pair whose `pair_en_i` bit is 0 holds its true output at 0 in both modes and shows no pulse. The other pairs are unaffected.
- R12: Each complementary output is always the inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the source and runs all logic |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_clk_i | input | 1 | Free-running source clock level to gate |
| wr_i | input | 1 | One-cycle strobe marking a completed byte write |
| wr_data_i | input | DATA_W | Byte being written (bit 7 shoot, bit 6 arm) |
| rd_data_o | output | DATA_W | Stored control byte |
| pair_en_i | input | NUM_PAIRS | Per-pair output enable |
| clk_p_o | output | NUM_PAIRS | True clock outputs |
| clk_n_o | output | NUM_PAIRS | Complementary clock outputs |

## Verification
The bench targets five corner cases:
- A repeated write of shoot=1. A design that tests the bit level instead of its edge would fire again.
- Back-to-back requests inside one waiting window. A design that queues them would emit two pulses.
- A shoot edge written with arm low and then followed by arming. A design that latches the request would fire late.
- A disarm right after a request. A wrong design would leave a stray pulse or keep the outputs stuck low.
- A change of the source half-period, with one pair disabled. A wrong design would show a pulse width that ignores the source phase, or a pulse leaking onto the disabled pair.

// File: rtl/ogate_pkg.sv
package ogate_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_FIRE} shot_st_e;
  localparam int unsigned ARM_BIT   = 6;
  localparam int unsigned SHOOT_BIT = 7;
endpackage

// File: rtl/ogate_regs.sv
module ogate_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              arm_o,
  output logic              shot_req_o,
  output logic              disarm_o
);
  import ogate_pkg::*;

  logic [DATA_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_i) ctrl_q <= wr_data_i;
  end

  assign rd_data_o = ctrl_q;
  assign arm_o     = ctrl_q[ARM_BIT];
  // edge judged against stored bit, only on a completed write, new arm must be set
  assign shot_req_o = wr_i & wr_data_i[SHOOT_BIT] & ~ctrl_q[SHOOT_BIT] & wr_data_i[ARM_BIT];
  assign disarm_o   = wr_i & ~wr_data_i[ARM_BIT];

  AST_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> rd_data_o == $past(wr_data_i)); // R3
  AST_HOLD_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(rd_data_o)); // R5
endmodule

// File: rtl/ogate_sync.sv
module ogate_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              lvl_d_q;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else chain_q[0] <= src_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[k] <= 1'b0;
          else chain_q[k] <= chain_q[k-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_d_q <= 1'b0;
    else lvl_d_q <= chain_q[STAGES-1];
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~lvl_d_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R6
endmodule

// File: rtl/ogate_fsm.sv
module ogate_fsm
  import ogate_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_i,
  input  logic      abort_i,
  input  logic      arm_i,
  input  logic      lvl_i,
  input  logic      rise_i,
  output logic      fire_o,
  output shot_st_e  st_o
);
  shot_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_i) st_d = ST_WAIT;
      ST_WAIT: if (rise_i) st_d = ST_FIRE;
      ST_FIRE: if (!lvl_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (abort_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else st_q <= st_d;
  end

  // high for the whole source high phase that follows the request
  assign fire_o = ((st_q == ST_WAIT) & rise_i) | ((st_q == ST_FIRE) & lvl_i);
  assign st_o   = st_q;

  AST_FIRE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FIRE && $past(st_q) != ST_FIRE) |-> $past(st_q) == ST_WAIT); // R6
  AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FIRE && lvl_i && req_i) |=> st_q == ST_FIRE); // R8
  AST_ACTIVE_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> arm_i); // R10
endmodule

// File: rtl/oneshot_clk_gate.sv
module oneshot_clk_gate #(
  parameter int unsigned NUM_PAIRS   = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 src_clk_i,
  input  logic                 wr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [DATA_W-1:0]    rd_data_o,
  input  logic [NUM_PAIRS-1:0] pair_en_i,
  output logic [NUM_PAIRS-1:0] clk_p_o,
  output logic [NUM_PAIRS-1:0] clk_n_o
);
  import ogate_pkg::*;

  logic      arm, shot_req, disarm, lvl, rise, fire, gated;
  shot_st_e  st;

  ogate_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .wr_data_i, .rd_data_o,
    .arm_o(arm), .shot_req_o(shot_req), .disarm_o(disarm)
  );

  ogate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .src_i(src_clk_i), .lvl_o(lvl), .rise_o(rise)
  );

  ogate_fsm u_fsm (
    .clk_i, .rst_ni, .req_i(shot_req), .abort_i(disarm), .arm_i(arm),
    .lvl_i(lvl), .rise_i(rise), .fire_o(fire), .st_o(st)
  );

  assign gated = arm ? fire : lvl;

  generate
    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
      logic out_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= 1'b0;
        else out_q <= gated & pair_en_i[i];
      end
      assign clk_p_o[i] = out_q;
      assign clk_n_o[i] = ~out_q;

      AST_PAIR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pair_en_i[i] |=> !clk_p_o[i]); // R11
      AST_ARMED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm && st == ST_IDLE) |=> !clk_p_o[i]); // R4
      AST_COMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clk_n_o[i] == !clk_p_o[i]); // R12
    end
  endgenerate
endmodule

// File: tb/oneshot_clk_gate_test.sv
`timescale 1ns/1ps
module oneshot_clk_gate_test;
  localparam int NP = 2;
  localparam int SY = 2;

  logic clk_i = 0, rst_ni = 0, src_clk_i = 0, wr_i = 0;
  logic [7:0] wr_data_i = 0;
  logic [7:0] rd_data_o;
  logic [NP-1:0] pair_en_i = '1, clk_p_o, clk_n_o;
  int total = 0, bad = 0, half = 5;
  bit done = 0;

  oneshot_clk_gate #(.NUM_PAIRS(NP), .SYNC_STAGES(SY), .DATA_W(8)) uut (.*);

  always #5 clk_i = ~clk_i;

  always begin
    repeat (half) @(negedge clk_i);
    src_clk_i = ~src_clk_i;
  end

  // behavioural reference
  bit [SY-1:0] m_sync;
  bit m_sd;
  int m_st;
  bit [7:0] m_ctrl;
  bit [NP-1:0] m_out;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sync = '0; m_sd = 0; m_st = 0; m_ctrl = 0; m_out = '0;
    end else begin
      bit s, rs, req, fire;
      int nst;
      s = m_sync[SY-1];
      rs = s & ~m_sd;
      req = wr_i & wr_data_i[7] & ~m_ctrl[7] & wr_data_i[6];
      fire = (m_st == 1 && rs) || (m_st == 2 && s);
      for (int i = 0; i < NP; i++) m_out[i] = pair_en_i[i] & (m_ctrl[6] ? fire : s);
      nst = m_st;
      if (m_st == 0 && req) nst = 1;
      else if (m_st == 1 && rs) nst = 2;
      else if (m_st == 2 && !s) nst = 0;
      if (wr_i && !wr_data_i[6]) nst = 0;
      m_st = nst;
      m_sd = s;
      m_sync = {m_sync[SY-2:0], src_clk_i};
      if (wr_i) m_ctrl = wr_data_i;
    end
  end

  always @(negedge clk_i) if (rst_ni && !done) begin
    total++;
    if (clk_p_o !== m_out || rd_data_o !== m_ctrl) begin
      bad++;
      $display("FAIL R2 R6 per-cycle: p=%b rd=%h expected p=%b rd=%h", clk_p_o, rd_data_o, m_out, m_ctrl);
    end
    total++;
    if (clk_n_o !== ~clk_p_o) begin
      bad++;
      $display("FAIL R12 complement: n=%b expected %b", clk_n_o, ~clk_p_o);
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk_i); wr_i = 1; wr_data_i = d;
    @(negedge clk_i); wr_i = 0;
  endtask

  task automatic watch(int n, output int e0, output int h0, output int e1, output int nlow0);
    bit p0, p1;
    e0 = 0; h0 = 0; e1 = 0; nlow0 = 0;
    p0 = clk_p_o[0]; p1 = clk_p_o[1];
    repeat (n) begin
      @(negedge clk_i);
      if (clk_p_o[0] && !p0) e0++;
      if (clk_p_o[1] && !p1) e1++;
      if (clk_p_o[0]) h0++;
      if (!clk_n_o[0]) nlow0++;
      p0 = clk_p_o[0]; p1 = clk_p_o[1];
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e0, h0, e1, nl;
    repeat (3) @(negedge clk_i);
    chk("R1 rd after reset", rd_data_o, 0);
    chk("R1 p after reset", clk_p_o, 0);
    chk("R1 n after reset", clk_n_o, 3);
    rst_ni = 1;

    watch(100, e0, h0, e1, nl);
    chk("R2 free-running edges", (e0 >= 9) ? 1 : 0, 1);

    wr(8'h40);
    chk("R3 readback", rd_data_o, 8'h40);
    repeat (3) @(negedge clk_i);
    watch(30, e0, h0, e1, nl);
    chk("R4 armed quiet high cycles", h0, 0);
    chk("R4 armed complement low cycles", nl, 0);

    @(negedge clk_i); wr_data_i = 8'hC0;
    watch(20, e0, h0, e1, nl);
    chk("R5 data without strobe", e0, 0);
    chk("R5 rd unchanged", rd_data_o, 8'h40);

    wr(8'hC0);
    watch(40, e0, h0, e1, nl);
    chk("R5 shot pulses", e0, 1);
    chk("R6 pulse width", h0, 5);

    wr(8'hC0);
    watch(40, e0, h0, e1, nl);
    chk("R7 repeated 1 no pulse", e0, 0);
    wr(8'h40); wr(8'hC0);
    watch(40, e0, h0, e1, nl);
    chk("R7 re-arm after 0", e0, 1);

    @(negedge clk_i); wr_i = 1; wr_data_i = 8'h40;
    @(negedge clk_i); wr_data_i = 8'hC0;
    @(negedge clk_i); wr_data_i = 8'h40;
    @(negedge clk_i); wr_data_i = 8'hC0;
    @(negedge clk_i); wr_i = 0;
    watch(40, e0, h0, e1, nl);
    chk("R8 busy request dropped", e0, 1);

    wr(8'h00); wr(8'h80); wr(8'hC0);
    repeat (3) @(negedge clk_i);
    watch(40, e0, h0, e1, nl);
    chk("R9 unarmed request discarded", e0, 0);

    wr(8'h40); wr(8'hC0); wr(8'h00);
    watch(40, e0, h0, e1, nl);
    chk("R10 disarm resumes toggling", (e0 >= 3) ? 1 : 0, 1);

    pair_en_i = 2'b10;
    wr(8'h40);
    repeat (3) @(negedge clk_i);
    wr(8'hC0);
    watch(40, e0, h0, e1, nl);
    chk("R11 disabled pair no pulse", e0, 0);
    chk("R11 disabled pair complement high", nl, 0);
    chk("R11 enabled pair pulses", e1, 1);
    pair_en_i = 2'b11;

    half = 7;
    wr(8'h40);
    repeat (30) @(negedge clk_i);
    wr(8'hC0);
    watch(50, e0, h0, e1, nl);
    chk("R6 width follows phase", h0, 7);
    chk("R6 single pulse", e0, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule